// File: doc/BRIEF.md
# Snapshot Statistics Counter Bank

This block holds a bank of wide event counters for a MAC. Receive and transmit logic raise one strobe per counter. A strobed event counter adds one. A strobed byte counter adds the frame length that arrives on a shared length input. Which counters are byte counters is chosen by a parameter mask.

A host sees the bank through a 16-bit register bus. A read returns a shadow copy of the counters, not the live values. One write to the control word copies every live counter into its shadow in the same cycle, so the three words of a wide counter always belong to the same instant. A second control bit zeroes the whole bank.

Every counter wraps to zero when it passes its maximum and then sets its own rollover flag. The flags are packed into four 16-bit words, and reading a word clears it. Four 16-bit mask words decide which flags drive the interrupt output.

Top module: `stat_snap_bank`

## Requirements
- R1: After a synchronous reset, every counter, shadow, rollover flag and mask is zero, `bus_rdata` is zero and `irq_o` is low.
- R2: A strobe on counter i adds 1 to that counter when bit i of BYTE_MASK is 0. When bit i is 1, it adds `ev_len` instead. Counters 0 and 1 are byte counters by default.
- R3: Counter i lives at word address 0x040 + 4*i. Offset 0 returns bits 15:0 and offset 1 returns bits 31:16. Offset 2 returns bits 39:32 in the low byte, with the high byte zero. Offset 3 reads zero.
- R4: Counter reads return the shadow copy. Events that arrive after a snapshot stay invisible until the next snapshot.
- R5: A write to address 0x000 with bit 0 set copies every live counter into its shadow in one cycle. An event in that same cycle goes into the live counter after the copy, so it appears at the following snapshot and is never lost.
- R6: A write to address 0x000 with bit 1 set zeroes every live counter, every shadow and every rollover flag. It overrides any event or snapshot in the same cycle.
- R7: A counter that passes its maximum wraps to zero. It then sets bit i%16 of rollover word i/16, which is read at address 0x004 + i/16.
- R8: Reading a rollover word returns its flags and clears them. A second read returns zero unless a new wrap occurred in between.
- R9: A wrap in the same cycle as a clear leaves the counter at zero and sets no rollover flag.
- R10: The mask words are at 0x008 to 0x00B and can be written and read back. `irq_o` is high exactly when some rollover flag has its mask bit set. The masks reset to zero, so a set flag alone raises no interrupt.
- R11: `bus_rdata` holds the addressed word in the cycle after `bus_rd`. It is zero in any other cycle and for any address that is not mapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_stb | input | NUM_CNT | One event strobe per counter |
| ev_len | input | LEN_W | Frame length added by strobed byte counters |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Registered read data |
| irq_o | output | 1 | Masked rollover interrupt |

## Verification
A wrong shadow or live value shows up on the next counter read after a snapshot, one cycle after `bus_rd`. A copy taken after the increment instead of before it shows up as a counter that is one too high at the snapshot where the collision happened. Rollover state can only be seen through the flag words and `irq_o`. A flag that is set wrongly or never cleared therefore shows up on the very next flag read, and on `irq_o` one cycle after a mask write.

A second instance with 16-bit counters makes wraps reachable in a few cycles. That instance exposes wrap, flag, clear-on-read and clear-priority faults within tens of cycles of the stimulus.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
    localparam int BUS_W      = 16;
    localparam int FLAG_WORDS = 4;
    localparam int FLAG_BITS  = FLAG_WORDS * BUS_W;
    // word-address groups (address >> 2)
    localparam int GRP_CTRL   = 0;
    localparam int GRP_FLAG   = 1;
    localparam int GRP_MASK   = 2;
    localparam int GRP_CNT0   = 16;

    typedef struct packed {
        logic clr;
        logic snap;
    } ctrl_cmd_t;

    typedef enum logic [1:0] {
        SLOT_LO  = 2'd0,
        SLOT_MID = 2'd1,
        SLOT_HI  = 2'd2,
        SLOT_PAD = 2'd3
    } cnt_slot_e;

    function automatic ctrl_cmd_t decode_ctrl(input logic [BUS_W-1:0] w);
        ctrl_cmd_t c;
        c.snap = w[0];
        c.clr  = w[1];
        return c;
    endfunction
endpackage

// File: rtl/ssb_counter.sv
module ssb_counter #(
    parameter int CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             snap,
    input  logic             inc,
    input  logic [CNT_W-1:0] amt,
    output logic [CNT_W-1:0] live,
    output logic [CNT_W-1:0] shadow,
    output logic             wrap
);
    logic [CNT_W:0] sum;

    assign sum  = {1'b0, live} + {1'b0, amt};
    assign wrap = inc && sum[CNT_W] && !clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            live   <= '0;
            shadow <= '0;
        end else begin
            if (snap) shadow <= live;
            if (inc)  live   <= sum[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/ssb_rd_decode.sv
module ssb_rd_decode
    import ssb_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int CNT_W   = 40,
    parameter int ADDR_W  = 9
) (
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]     shadow,
    input  logic [FLAG_WORDS-1:0][BUS_W-1:0]  flags,
    input  logic [FLAG_WORDS-1:0][BUS_W-1:0]  masks,
    output logic [BUS_W-1:0]                  rdata
);
    localparam int GRP_W = ADDR_W - 2;

    logic [GRP_W-1:0] grp;
    cnt_slot_e        slot;
    logic [47:0]      wide;

    assign grp  = addr[ADDR_W-1:2];
    assign slot = cnt_slot_e'(addr[1:0]);

    always_comb begin
        wide = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (int'(grp) == GRP_CNT0 + i) wide = 48'(shadow[i]);
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(grp) == GRP_FLAG) begin
            rdata = flags[addr[1:0]];
        end else if (int'(grp) == GRP_MASK) begin
            rdata = masks[addr[1:0]];
        end else if (int'(grp) >= GRP_CNT0 && int'(grp) < GRP_CNT0 + NUM_CNT) begin
            unique case (slot)
                SLOT_LO:  rdata = wide[15:0];
                SLOT_MID: rdata = wide[31:16];
                SLOT_HI:  rdata = {8'h00, wide[39:32]};
                SLOT_PAD: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/stat_snap_bank.sv
module stat_snap_bank
    import ssb_pkg::*;
#(
    parameter int          NUM_CNT   = 8,
    parameter int          CNT_W     = 40,
    parameter int          LEN_W     = 14,
    parameter int          ADDR_W    = 9,
    parameter logic [63:0] BYTE_MASK = 64'h3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CNT-1:0] ev_stb,
    input  logic [LEN_W-1:0]   ev_len,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [15:0]        bus_wdata,
    output logic [15:0]        bus_rdata,
    output logic               irq_o
);
    localparam int GRP_W = ADDR_W - 2;

    logic [GRP_W-1:0]                grp;
    ctrl_cmd_t                       cmd;
    logic                            snap_cmd;
    logic                            clr_cmd;
    logic [NUM_CNT-1:0][CNT_W-1:0]   live_q;
    logic [NUM_CNT-1:0][CNT_W-1:0]   shadow_q;
    logic [NUM_CNT-1:0]              wrap_vec;
    logic [FLAG_WORDS-1:0][BUS_W-1:0] flag_q;
    logic [FLAG_WORDS-1:0][BUS_W-1:0] mask_q;
    logic [FLAG_WORDS-1:0][BUS_W-1:0] set_w;
    logic [BUS_W-1:0]                dec_data;

    assign grp      = bus_addr[ADDR_W-1:2];
    assign cmd      = decode_ctrl(bus_wdata);
    assign snap_cmd = bus_wr && int'(grp) == GRP_CTRL && bus_addr[1:0] == 2'd0 && cmd.snap;
    assign clr_cmd  = bus_wr && int'(grp) == GRP_CTRL && bus_addr[1:0] == 2'd0 && cmd.clr;

    generate
        for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
            logic [CNT_W-1:0] amt;
            if (BYTE_MASK[i]) begin : g_byte
                assign amt = CNT_W'(ev_len);
            end else begin : g_event
                assign amt = CNT_W'(1);
            end
            ssb_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk    (clk),
                .rst    (rst),
                .clr    (clr_cmd),
                .snap   (snap_cmd),
                .inc    (ev_stb[i]),
                .amt    (amt),
                .live   (live_q[i]),
                .shadow (shadow_q[i]),
                .wrap   (wrap_vec[i])
            );
        end
    endgenerate

    assign set_w = FLAG_BITS'(wrap_vec);

    always_ff @(posedge clk) begin
        if (rst || clr_cmd) begin
            flag_q <= '0;
        end else begin
            for (int w = 0; w < FLAG_WORDS; w++) begin
                if (bus_rd && int'(grp) == GRP_FLAG && int'(bus_addr[1:0]) == w)
                    flag_q[w] <= set_w[w];
                else
                    flag_q[w] <= flag_q[w] | set_w[w];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (bus_wr && int'(grp) == GRP_MASK) begin
            mask_q[bus_addr[1:0]] <= bus_wdata;
        end
    end

    ssb_rd_decode #(
        .NUM_CNT (NUM_CNT),
        .CNT_W   (CNT_W),
        .ADDR_W  (ADDR_W)
    ) u_dec (
        .addr   (bus_addr),
        .shadow (shadow_q),
        .flags  (flag_q),
        .masks  (mask_q),
        .rdata  (dec_data)
    );

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= bus_rd ? dec_data : '0;
    end

    assign irq_o = |(flag_q & mask_q);
endmodule

// File: rtl/stat_snap_bank_chk.sv
module stat_snap_bank_chk #(
    parameter int NUM_CNT = 8,
    parameter int CNT_W   = 40
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          bus_rd,
    input logic [15:0]                   bus_rdata,
    input logic                          irq_o,
    input logic                          snap_cmd,
    input logic                          clr_cmd,
    input logic [NUM_CNT-1:0][CNT_W-1:0] live_q,
    input logic [NUM_CNT-1:0][CNT_W-1:0] shadow_q,
    input logic [3:0][15:0]              flag_q,
    input logic [3:0][15:0]              mask_q
);
    assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> bus_rdata == 16'h0);

    assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!snap_cmd && !clr_cmd) |=> $stable(shadow_q));

    assert_snap_copy_R5: assert property (@(posedge clk) disable iff (rst)
        (snap_cmd && !clr_cmd) |=> shadow_q == $past(live_q));

    assert_clear_cnt_R6: assert property (@(posedge clk) disable iff (rst)
        clr_cmd |=> (live_q == '0 && shadow_q == '0));

    assert_clear_flag_R9: assert property (@(posedge clk) disable iff (rst)
        clr_cmd |=> flag_q == '0);

    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (mask_q != '0 && flag_q != '0));
endmodule

bind stat_snap_bank stat_snap_bank_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/stat_snap_bank_tb.sv
module stat_snap_bank_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  ev_stb;
    logic [13:0] ev_len;
    logic        bus_wr, bus_rd;
    logic [8:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] rd_big, rd_sml;
    logic        irq_big, irq_sml;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 0;

    always #(CLK_P/2) clk = ~clk;

    stat_snap_bank u_dut (
        .clk(clk), .rst(rst), .ev_stb(ev_stb), .ev_len(ev_len),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_big), .irq_o(irq_big)
    );

    stat_snap_bank #(.CNT_W(16)) u_sml (
        .clk(clk), .rst(rst), .ev_stb(ev_stb), .ev_len(ev_len),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_sml), .irq_o(irq_sml)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [8:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [8:0] a, output logic [15:0] big,
                            output logic [15:0] sml);
        bus_rd = 1'b1; bus_addr = a;
        step();
        big = rd_big; sml = rd_sml;
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] m, input logic [13:0] len);
        ev_stb = m; ev_len = len;
        step();
        ev_stb = '0;
    endtask

    task automatic read_cnt(input int idx, output logic [39:0] big,
                            output logic [39:0] sml);
        logic [15:0] b0, b1, b2, s0, s1, s2;
        bus_read(9'(64 + 4*idx), b0, s0);
        bus_read(9'(65 + 4*idx), b1, s1);
        bus_read(9'(66 + 4*idx), b2, s2);
        big = {b2[7:0], b1, b0};
        sml = {s2[7:0], s1, s0};
    endtask

    task automatic t_reset();
        logic [39:0] b, s;
        chk("R1", "rdata after reset", 40'(rd_big), 40'h0);
        chk("R1", "irq after reset", 40'(irq_big | irq_sml), 40'h0);
        bus_write(9'h000, 16'h0001);
        read_cnt(2, b, s);
        chk("R1", "counter 2 after reset", b, 40'h0);
    endtask

    task automatic t_count();
        logic [39:0] b, s;
        logic [15:0] pb, ps;
        for (int k = 0; k < 3; k++) pulse(8'h04, 14'd77);
        pulse(8'h01, 14'd1000);
        pulse(8'h08, 14'd500);
        bus_write(9'h000, 16'h0001);
        read_cnt(2, b, s);
        chk("R2", "event counter 2", b, 40'd3);
        read_cnt(0, b, s);
        chk("R2", "byte counter 0", b, 40'd1000);
        read_cnt(3, b, s);
        chk("R2", "event counter 3 ignores length", b, 40'd1);
        bus_read(9'h043, pb, ps);
        chk("R3", "pad slot of counter 0", 40'(pb), 40'h0);
    endtask

    task automatic t_shadow();
        logic [39:0] b, s;
        pulse(8'h04, 14'd0);
        read_cnt(2, b, s);
        chk("R4", "shadow unchanged without snapshot", b, 40'd3);
        bus_write(9'h000, 16'h0001);
        read_cnt(2, b, s);
        chk("R4", "shadow after snapshot", b, 40'd4);
    endtask

    task automatic t_snap_inc();
        logic [39:0] b, s;
        ev_stb = 8'h04;
        bus_write(9'h000, 16'h0001);
        ev_stb = '0;
        read_cnt(2, b, s);
        chk("R5", "snapshot takes pre-increment value", b, 40'd4);
        bus_write(9'h000, 16'h0001);
        read_cnt(2, b, s);
        chk("R5", "colliding increment kept", b, 40'd5);
    endtask

    task automatic t_clear();
        logic [39:0] b, s;
        bus_write(9'h000, 16'h0002);
        read_cnt(0, b, s);
        chk("R6", "shadow zero after clear", b, 40'd0);
        bus_write(9'h000, 16'h0001);
        read_cnt(2, b, s);
        chk("R6", "live zero after clear", b, 40'd0);
    endtask

    task automatic t_wide_wrap();
        logic [39:0] b, s;
        logic [15:0] pb, ps;
        for (int k = 0; k < 5; k++) pulse(8'h01, 14'd16383);
        bus_write(9'h000, 16'h0001);
        read_cnt(0, b, s);
        chk("R3", "40-bit counter across words", b, 40'h13FFB);
        chk("R7", "16-bit counter wrapped", s, 40'h3FFB);
        bus_read(9'h042, pb, ps);
        chk("R3", "top word high byte zero", 40'(pb), 40'h0);
        chk("R10", "no irq with masks at zero", 40'(irq_sml), 40'h0);
        bus_write(9'h008, 16'h0001);
        chk("R10", "irq after mask set", 40'(irq_sml), 40'h1);
        chk("R10", "no irq without flag", 40'(irq_big), 40'h0);
        bus_read(9'h008, pb, ps);
        chk("R10", "mask read back", 40'(ps), 40'h0001);
        bus_read(9'h004, pb, ps);
        chk("R7", "rollover flag bit 0", 40'(ps), 40'h0001);
        chk("R7", "no rollover on wide counter", 40'(pb), 40'h0);
        bus_read(9'h004, pb, ps);
        chk("R8", "flag cleared by read", 40'(ps), 40'h0);
        chk("R8", "irq drops after flag read", 40'(irq_sml), 40'h0);
    endtask

    task automatic t_clr_wrap();
        logic [39:0] b, s;
        logic [15:0] pb, ps;
        bus_write(9'h000, 16'h0002);
        for (int k = 0; k < 4; k++) pulse(8'h01, 14'd16383);
        ev_stb = 8'h01; ev_len = 14'd16383;
        bus_write(9'h000, 16'h0002);
        ev_stb = '0;
        bus_write(9'h000, 16'h0001);
        read_cnt(0, b, s);
        chk("R9", "counter zero when clear meets wrap", s, 40'h0);
        bus_read(9'h004, pb, ps);
        chk("R9", "no flag when clear meets wrap", 40'(ps), 40'h0);
    endtask

    task automatic t_unmapped();
        logic [15:0] pb, ps;
        bus_read(9'h003, pb, ps);
        chk("R11", "unmapped 0x003", 40'(pb), 40'h0);
        bus_read(9'h00C, pb, ps);
        chk("R11", "unmapped 0x00C", 40'(pb), 40'h0);
        bus_read(9'h060, pb, ps);
        chk("R11", "past last counter", 40'(pb), 40'h0);
        step();
        chk("R11", "rdata zero when idle", 40'(rd_big), 40'h0);
    endtask

    initial begin
        rst = 1'b1; ev_stb = '0; ev_len = '0;
        bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_count();
        t_shadow();
        t_snap_inc();
        t_clear();
        t_wide_wrap();
        t_clr_wrap();
        t_unmapped();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule